// File: doc/BRIEF.md
# Two-Group Masked Interrupt Aggregator

This block gathers sixteen level interrupt sources into two groups of eight and drives one processor interrupt line per group. Each group keeps a status byte, which records which of its sources are pending, and a mask byte, which selects which pending sources may reach the line. Peripherals change status by presenting a set or clear bit mask for one clock cycle. Software sees the block through a byte-wide register port addressed at word-aligned offsets.

Status can be changed only by the peripheral requests; software writes to a status offset are dropped. Software can write the two masks. Three extra registers for mappable interrupts (two masks and a polarity byte) hold what software writes and return it on read, but they do not affect either line. The map status, timer clear and error status offsets always read zero.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is high at a clock edge, every register is cleared to zero on that edge. After reset, both interrupt lines are low and every offset reads zero.
- R2: A nonzero raise mask presented for one cycle ORs its bits into that group's status on the next clock edge. Group 0 bits, from bit 0 upward, belong to: FIFO, SCSI0, SCSI1, Ethernet, memory-controller DMA, parallel, graphics, mappable0. Group 1 bits, from bit 0 upward, belong to: GP0, front panel, GP2, mappable1, HPC DMA, AC fail, vsync, retrace.
- R3: A lower mask clears its bits in that group's status on the next clock edge. All other status bits keep their value.
- R4: When a raise and a lower name the same bit in the same cycle, the bit ends up set.
- R5: Each group's line is high exactly when the status and mask of that group share at least one set bit. The line is combinational from the registers, so it changes in the same cycle that the status or mask changes, with no further delay.
- R6: Offsets 0x80 and 0x88 read status of group 0 and group 1. Offsets 0x84 and 0x8c read and write mask of group 0 and group 1. A mask write takes effect on the clock edge that samples the write strobe.
- R7: Writes to 0x80, 0x88, 0x90 and 0xa4 are ignored. A status register changes only through raise and lower requests.
- R8: Offsets 0x94, 0x98 and 0x9c (map mask 0, map mask 1, map polarity) store written bytes and read them back. Writing them never changes either line.
- R9: The two groups are independent. Requests and mask writes for one group never change the other group's status, mask or line.
- R10: Offsets 0x90, 0xa0, 0xa4 and every offset not listed here read zero. Writes to an unlisted offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| raise0_i | input | 8 | Set mask for group 0 status, one-cycle pulse |
| lower0_i | input | 8 | Clear mask for group 0 status, one-cycle pulse |
| raise1_i | input | 8 | Set mask for group 1 status, one-cycle pulse |
| lower1_i | input | 8 | Clear mask for group 1 status, one-cycle pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| irq0_o | output | 1 | Interrupt line of group 0 |
| irq1_o | output | 1 | Interrupt line of group 1 |

## Verification
The main function is tested with several input patterns:
- Single-bit raises that are not masked separate pending status from a line that is actually driven.
- Changing masks over a fixed status shows that the line follows the status-and-mask overlap and not the status alone.
- Mixed raise and lower masks in the same cycle, on different bits and on the same bit, show that the update is bit by bit and that set takes priority over clear.
- Traffic on one group while the other is idle shows that the groups are separate.
- Writes to status, map and unlisted offsets show which registers store data and which never change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int SRC_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = SRC_W;
    localparam int GROUPS  = 2;
    localparam int MAP_REGS = 3;
    localparam int GRP_STRIDE = 8;

    typedef logic [SRC_W-1:0]  src_vec_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [ADDR_W-1:0] {
        OFS_STAT0   = 8'h80,
        OFS_MASK0   = 8'h84,
        OFS_STAT1   = 8'h88,
        OFS_MASK1   = 8'h8C,
        OFS_MAPSTAT = 8'h90,
        OFS_MAPM0   = 8'h94,
        OFS_MAPM1   = 8'h98,
        OFS_MAPPOL  = 8'h9C,
        OFS_TCLR    = 8'hA0,
        OFS_ERRSTAT = 8'hA4
    } reg_ofs_e;

    typedef struct packed {
        src_vec_t status;
        src_vec_t mask;
    } grp_state_t;

    // set has priority over clear on the same bit
    function automatic src_vec_t next_status(src_vec_t cur, src_vec_t set_v, src_vec_t clr_v);
        return (cur & ~clr_v) | set_v;
    endfunction

    function automatic addr_t stat_ofs(int g);
        return addr_t'(OFS_STAT0) + addr_t'(g * GRP_STRIDE);
    endfunction

    function automatic addr_t mask_ofs(int g);
        return addr_t'(OFS_MASK0) + addr_t'(g * GRP_STRIDE);
    endfunction

    function automatic addr_t map_ofs(int i);
        return addr_t'(OFS_MAPM0) + addr_t'(i * 4);
    endfunction

endpackage

// File: rtl/irq_group.sv
module irq_group
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   raise_i,
    input  src_vec_t   lower_i,
    input  logic       mask_we_i,
    input  src_vec_t   mask_wdata_i,
    output grp_state_t state_o,
    output logic       line_o
);

    grp_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q.status <= next_status(state_q.status, raise_i, lower_i);
            if (mask_we_i) begin
                state_q.mask <= mask_wdata_i;
            end
        end
    end

    assign state_o = state_q;
    assign line_o  = |(state_q.status & state_q.mask);

    AST_GRP_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (state_o == '0 && !line_o)); // R1

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (rst)
        (|raise_i) |=> ((state_o.status & $past(raise_i)) == $past(raise_i))); // R4

    AST_LOWER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (|(lower_i & ~raise_i)) |=> ((state_o.status & $past(lower_i & ~raise_i)) == '0)); // R3

    AST_STATUS_ONLY_BY_REQ: assert property (@(posedge clk) disable iff (rst)
        (raise_i == '0 && lower_i == '0) |=> $stable(state_o.status)); // R7

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
        !mask_we_i |=> $stable(state_o.mask)); // R6

endmodule

// File: rtl/irq_map_store.sv
module irq_map_store
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  addr_t    addr_i,
    input  src_vec_t wdata_i,
    output src_vec_t map_o [MAP_REGS]
);

    for (genvar i = 0; i < MAP_REGS; i++) begin : g_map
        src_vec_t val_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (wr_i && addr_i == map_ofs(i)) begin
                val_q <= wdata_i;
            end
        end
        assign map_o[i] = val_q;

        AST_MAP_RESET_CLEAR: assert property (@(posedge clk)
            rst |=> (map_o[i] == '0)); // R1
    end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_agg_pkg::*;
(
    input  logic       wr_i,
    input  addr_t      addr_i,
    input  grp_state_t grp_i [GROUPS],
    input  src_vec_t   map_i [MAP_REGS],
    output logic       mask_we_o [GROUPS],
    output src_vec_t   rdata_o
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_dec
        assign mask_we_o[g] = wr_i && (addr_i == mask_ofs(g));
    end

    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (addr_i == stat_ofs(g)) rdata_o = grp_i[g].status;
            if (addr_i == mask_ofs(g)) rdata_o = grp_i[g].mask;
        end
        for (int i = 0; i < MAP_REGS; i++) begin
            if (addr_i == map_ofs(i)) rdata_o = map_i[i];
        end
    end

    always_comb begin
        if (addr_i == addr_t'(OFS_TCLR) || addr_i == addr_t'(OFS_ERRSTAT)
            || addr_i == addr_t'(OFS_MAPSTAT)) begin
            AST_ZERO_OFFSETS: assert (rdata_o == '0); // R10
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] raise0_i,
    input  logic [7:0] lower0_i,
    input  logic [7:0] raise1_i,
    input  logic [7:0] lower1_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       irq0_o,
    output logic       irq1_o
);

    src_vec_t   raise_v [GROUPS];
    src_vec_t   lower_v [GROUPS];
    grp_state_t grp_st  [GROUPS];
    logic       grp_line [GROUPS];
    logic       mask_we [GROUPS];
    src_vec_t   map_v   [MAP_REGS];

    assign raise_v[0] = raise0_i;
    assign raise_v[1] = raise1_i;
    assign lower_v[0] = lower0_i;
    assign lower_v[1] = lower1_i;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        irq_group u_grp (
            .clk          (clk),
            .rst          (rst),
            .raise_i      (raise_v[g]),
            .lower_i      (lower_v[g]),
            .mask_we_i    (mask_we[g]),
            .mask_wdata_i (reg_wdata_i),
            .state_o      (grp_st[g]),
            .line_o       (grp_line[g])
        );
    end

    irq_map_store u_map (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .map_o   (map_v)
    );

    irq_reg_port u_port (
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .grp_i     (grp_st),
        .map_i     (map_v),
        .mask_we_o (mask_we),
        .rdata_o   (reg_rdata_o)
    );

    assign irq0_o = grp_line[0];
    assign irq1_o = grp_line[1];

    logic map_wr;
    assign map_wr = reg_wr_i && (reg_addr_i == addr_t'(OFS_MAPM0) || reg_addr_i == addr_t'(OFS_MAPM1)
                                 || reg_addr_i == addr_t'(OFS_MAPPOL));

    AST_MAP_NO_LINE_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (map_wr && raise0_i == '0 && lower0_i == '0 && raise1_i == '0 && lower1_i == '0)
        |=> ($stable(irq0_o) && $stable(irq1_o))); // R8

    AST_GRP0_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        (raise0_i == '0 && lower0_i == '0 && !(reg_wr_i && reg_addr_i == addr_t'(OFS_MASK0)))
        |=> $stable(irq0_o)); // R9

    AST_GRP1_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        (raise1_i == '0 && lower1_i == '0 && !(reg_wr_i && reg_addr_i == addr_t'(OFS_MASK1)))
        |=> $stable(irq1_o)); // R9

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] raise0 = '0, lower0 = '0, raise1 = '0, lower1 = '0;
    logic       wr = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       irq0, irq1;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [7:0] m_s0 = '0, m_m0 = '0, m_s1 = '0, m_m1 = '0;

    always #2 clk = ~clk;

    irq_aggregator u_dut (
        .clk (clk), .rst (rst),
        .raise0_i (raise0), .lower0_i (lower0),
        .raise1_i (raise1), .lower1_i (lower1),
        .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
        .reg_rdata_o (rdata), .irq0_o (irq0), .irq1_o (irq1)
    );

    // fields: raise0, lower0, raise1, lower1, wr, addr, wdata
    localparam int NVEC = 12;
    localparam logic [48:0] VEC [NVEC] = '{
        {8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},  // R2 FIFO pending, masked
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h84, 8'h01},  // R5 R6 unmask FIFO
        {8'h00, 8'h00, 8'h82, 8'h00, 1'b1, 8'h8C, 8'h80},  // R9 group1 panel+retrace
        {8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},  // R3 lower FIFO
        {8'hF0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},  // R2 upper nibble
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h84, 8'h30},  // R5 mask overlap
        {8'h00, 8'h00, 8'h00, 8'h80, 1'b0, 8'h00, 8'h00},  // R3 group1 lower
        {8'h0F, 8'hF0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},  // R3 mixed
        {8'h00, 8'h00, 8'h01, 8'h02, 1'b1, 8'h8C, 8'h01},  // R5 R9
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h84, 8'h00},  // R5 mask all off
        {8'h08, 8'h08, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},  // R4 same bit
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h80, 8'h00}   // R7 status write
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic step(input logic [7:0] r0, l0, r1, l1, input logic w,
                        input logic [7:0] a, d);
        @(negedge clk);
        raise0 = r0; lower0 = l0; raise1 = r1; lower1 = l1;
        wr = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        raise0 = '0; lower0 = '0; raise1 = '0; lower1 = '0; wr = 1'b0;
        m_s0 = (m_s0 & ~l0) | r0;
        m_s1 = (m_s1 & ~l1) | r1;
        if (w && a == 8'h84) m_m0 = d;
        if (w && a == 8'h8C) m_m1 = d;
    endtask

    task automatic check_all(input string req);
        #1;
        check({req, " irq0"}, {7'd0, irq0}, {7'd0, |(m_s0 & m_m0)});
        check({req, " irq1"}, {7'd0, irq1}, {7'd0, |(m_s1 & m_m1)});
        read_chk({req, " status0"}, 8'h80, m_s0);
        read_chk({req, " mask0"},   8'h84, m_m0);
        read_chk({req, " status1"}, 8'h88, m_s1);
        read_chk({req, " mask1"},   8'h8C, m_m1);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 irq0", {7'd0, irq0}, 8'h00);
        check("R1 irq1", {7'd0, irq1}, 8'h00);
        for (int a = 8'h80; a <= 8'hA4; a += 4) read_chk("R1 reset read", 8'(a), 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][48:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17],
                 VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
            check_all($sformatf("vec%0d R2 R3 R5 R6", i));
        end

        // R4: raise and lower of bit 0 together, bit currently clear
        step(8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00);
        step(8'h01, 8'h01, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00);
        read_chk("R4 raise wins", 8'h80, 8'h0F);

        // R7: status writes ignored on all read-only offsets
        step(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h88, 8'hFF);
        step(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h90, 8'hFF);
        step(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'hA4, 8'hFF);
        check_all("R7 ro writes");
        read_chk("R7 map status", 8'h90, 8'h00);
        read_chk("R7 err status", 8'hA4, 8'h00);

        // R8: map registers store, lines unchanged
        step(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h94, 8'hFF);
        step(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h98, 8'hA5);
        step(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h9C, 8'h3C);
        read_chk("R8 map mask0", 8'h94, 8'hFF);
        read_chk("R8 map mask1", 8'h98, 8'hA5);
        read_chk("R8 map pol",   8'h9C, 8'h3C);
        check_all("R8 lines unchanged");

        // R10: timer clear and unlisted offsets
        step(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'hA0, 8'h77);
        read_chk("R10 timer clear", 8'hA0, 8'h00);
        step(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h40, 8'h55);
        read_chk("R10 unlisted", 8'h40, 8'h00);
        check_all("R10 no side effect");

        // R9: full raise on group 1 only
        step(8'h00, 8'h00, 8'hFF, 8'h00, 1'b1, 8'h8C, 8'hFF);
        check_all("R9 group1 only");

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_s0 = '0; m_m0 = '0; m_s1 = '0; m_m1 = '0;
        check_all("R1 mid reset");
        read_chk("R1 map mask0", 8'h94, 8'h00);
        read_chk("R1 map pol",   8'h9C, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule